// File: doc/BRIEF.md
# Bus START/STOP Condition Qualifier

This block observes the clock and data lines of a two-wire serial bus and decides when a START or a STOP condition has really happened. A START is the data line falling while the clock line is high; a STOP is the data line rising while the clock line is high. An edge of that kind only counts when three timing windows are all met. The clock line must have been high long enough before the edge (release). The data line must have held its old level long enough before the edge (setup). The clock line must stay high, and the data line must keep its new level, long enough after the edge (hold). The window lengths come from a 5-bit timing value and a standard/fast mode select.

A qualified START sets a bus-busy flag and a qualified STOP clears it. The flag changes a fixed number of cycles after the edge rather than at once. When the block is configured as a slave, each qualified STOP also produces a one-cycle interrupt pulse. Both bus lines pass through two-flop synchronizers first. A configuration port loads the timing value, the mode and the master/slave role. Loading an illegal timing value (zero or odd) raises a sticky error output and turns detection off until a legal value is loaded.

The controller has four states. OFF means detection is disabled by a configuration error. IDLE watches for a candidate edge. HOLD counts hold cycles after a candidate. WAIT runs out the remaining flag delay. Its transitions are: OFF→IDLE when the error clears; IDLE→HOLD on a candidate that meets release and setup; HOLD→IDLE on discard (clock low or data reverted before hold completes); HOLD→IDLE on commit when the delay is already reached; HOLD→WAIT on hold met with delay pending; WAIT→IDLE on commit; and any state→OFF while the error is set.

Top module: `i2c_cond_detect`

## Requirements
- R1: After reset, bus_busy, stop_irq and cfg_err are 0, and the block behaves as if the timing value 24, standard mode and slave role had been loaded.
- R2: A START is qualified when SDA is sampled low at rising edge e0 after being sampled high, with release, setup and hold met. bus_busy becomes 1 on rising edge e0+1+D, where D is the flag delay, and not earlier.
- R3: A STOP (SDA sampled high at e0 after being sampled low) with release, setup and hold met clears bus_busy on rising edge e0+1+D.
- R4: In standard mode, with timing value N, the windows are as follows. Release: SCL sampled high on the N+1 edges before e0 and at e0. Setup: SDA at its old level on N/2+1 edges before e0. Hold: SCL high and SDA at its new level on N/2 edges from e0. Delay: D = N/2+1.
- R5: In fast mode the windows are release 4, setup 2, hold 2 and delay D = 4, whatever the timing value.
- R6: An edge whose release is one cycle short of the window changes neither bus_busy nor stop_irq.
- R7: An edge whose setup is short of the window changes neither bus_busy nor stop_irq.
- R8: If SCL falls, or SDA returns to its old level, before the hold window completes, the candidate is discarded and neither output changes.
- R9: A qualified STOP in slave role (master bit 0) drives stop_irq high for exactly the one cycle after edge e0+1+D. There is no pulse in master role and none for a START.
- R10: A configuration write with a timing value of 0 or an odd value sets cfg_err on the write edge and disables detection. A later write of a legal value clears cfg_err and re-enables detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| cfg_we | input | 1 | Load cfg_ssc, cfg_fast and cfg_master on this edge |
| cfg_ssc | input | 5 | Timing value (even, non-zero) |
| cfg_fast | input | 1 | 1 selects the fixed fast-mode windows |
| cfg_master | input | 1 | 1 selects master role (no stop interrupt) |
| bus_busy | output | 1 | Set by a qualified START, cleared by a qualified STOP |
| stop_irq | output | 1 | One-cycle pulse on a qualified STOP in slave role |
| cfg_err | output | 1 | Sticky illegal-timing-value flag |

## Verification
A controller stuck outside IDLE shows up as the next qualified START or STOP never reaching bus_busy. A wrong timer or window value moves the bus_busy edge off cycle e0+1+D, or lets a one-cycle-short window through. Because the bench samples bus_busy and stop_irq on every cycle from e0 to past the expected commit edge, an error of a single cycle in any window or delay is reported within that same condition. A spurious or doubled stop_irq is reported in the cycle it occurs.

// File: rtl/i2c_cd_pkg.sv
package i2c_cd_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_HOLD = 2'd2,
        ST_WAIT = 2'd3
    } cd_state_t;

endpackage

// File: rtl/i2c_cd_sync.sv
module i2c_cd_sync #(
    parameter int            N       = 2,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else begin
                    if (s == 0) chain[s] <= d;
                    else        chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cd_runlen.sv
module i2c_cd_runlen #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         restart_one,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= restart_one ? W'(1) : '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6/R7 run-length counters restart low
    a_r6_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt <= W'(1)));
endmodule

// File: rtl/i2c_cd_windows.sv
module i2c_cd_windows #(
    parameter int SSC_W     = 5,
    parameter int CNT_W     = 7,
    parameter int FAST_REL  = 4,
    parameter int FAST_SET  = 2,
    parameter int FAST_HOLD = 2,
    parameter int FAST_DLY  = 4
) (
    input  logic [SSC_W-1:0] ssc,
    input  logic             fast,
    output logic [CNT_W-1:0] rel_n,
    output logic [CNT_W-1:0] set_n,
    output logic [CNT_W-1:0] hold_n,
    output logic [CNT_W-1:0] dly_n
);
    logic [CNT_W-1:0] full, half;

    assign full = CNT_W'(ssc);
    assign half = CNT_W'(ssc >> 1);

    always_comb begin
        if (fast) begin
            rel_n  = CNT_W'(FAST_REL);
            set_n  = CNT_W'(FAST_SET);
            hold_n = CNT_W'(FAST_HOLD);
            dly_n  = CNT_W'(FAST_DLY);
        end else begin
            rel_n  = full + 1'b1;
            set_n  = half + 1'b1;
            hold_n = half;
            dly_n  = half + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cd_pkg::*;
#(
    parameter int SSC_W     = 5,
    parameter int CNT_W     = 7,
    parameter int RESET_SSC = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             cfg_we,
    input  logic [SSC_W-1:0] cfg_ssc,
    input  logic             cfg_fast,
    input  logic             cfg_master,
    output logic             bus_busy,
    output logic             stop_irq,
    output logic             cfg_err
);
    localparam logic [SSC_W-1:0] RST_SSC = SSC_W'(RESET_SSC);

    // configuration
    logic [SSC_W-1:0] ssc_q;
    logic             fast_q, master_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ssc_q    <= RST_SSC;
            fast_q   <= 1'b0;
            master_q <= 1'b0;
            cfg_err  <= 1'b0;
        end else if (cfg_we) begin
            ssc_q    <= cfg_ssc;
            fast_q   <= cfg_fast;
            master_q <= cfg_master;
            cfg_err  <= (cfg_ssc == '0) || cfg_ssc[0];
        end
    end

    // synchronized lines
    logic [1:0] lines_s;
    logic       s_scl, s_sda, sda_d, sda_edge;

    i2c_cd_sync #(.N(2), .STAGES(2), .RST_VAL(2'b11)) i_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
    );
    assign s_scl = lines_s[1];
    assign s_sda = lines_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_d <= 1'b1;
        else        sda_d <= s_sda;
    end
    assign sda_edge = s_sda ^ sda_d;

    // run lengths
    logic [CNT_W-1:0] scl_run, sda_run;

    i2c_cd_runlen #(.W(CNT_W)) i_scl_run (
        .clk(clk), .rst_n(rst_n), .restart(!s_scl), .restart_one(1'b0), .cnt(scl_run)
    );
    i2c_cd_runlen #(.W(CNT_W)) i_sda_run (
        .clk(clk), .rst_n(rst_n), .restart(sda_edge), .restart_one(1'b1), .cnt(sda_run)
    );

    // windows
    logic [CNT_W-1:0] rel_n, set_n, hold_n, dly_n, dly_m1;

    i2c_cd_windows #(.SSC_W(SSC_W), .CNT_W(CNT_W)) i_win (
        .ssc(ssc_q), .fast(fast_q),
        .rel_n(rel_n), .set_n(set_n), .hold_n(hold_n), .dly_n(dly_n)
    );
    assign dly_m1 = dly_n - 1'b1;

    // controller
    cd_state_t        state, nxt;
    logic [CNT_W-1:0] tmr;
    logic             kind_start;
    logic             cand, bad, hold_met, dly_met, commit;

    assign cand     = s_scl && sda_edge && (scl_run >= rel_n) && (sda_run >= set_n);
    assign bad      = !s_scl || (s_sda != !kind_start);
    assign hold_met = (tmr >= hold_n);
    assign dly_met  = (tmr >= dly_m1);
    assign commit   = !cfg_err &&
                      (((state == ST_HOLD) && hold_met && dly_met) ||
                       ((state == ST_WAIT) && dly_met));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  nxt = ST_IDLE;
            ST_IDLE: if (cand) nxt = ST_HOLD;
            ST_HOLD: begin
                if (hold_met)  nxt = dly_met ? ST_IDLE : ST_WAIT;
                else if (bad)  nxt = ST_IDLE;
            end
            ST_WAIT: if (dly_met) nxt = ST_IDLE;
            default: nxt = ST_OFF;
        endcase
        if (cfg_err) nxt = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr        <= '0;
            kind_start <= 1'b0;
            bus_busy   <= 1'b0;
            stop_irq   <= 1'b0;
        end else begin
            stop_irq <= 1'b0;
            if (state == ST_IDLE && cand) begin
                tmr        <= CNT_W'(1);
                kind_start <= !s_sda;
            end else if (state == ST_HOLD || state == ST_WAIT) begin
                tmr <= tmr + 1'b1;
            end
            if (commit) begin
                bus_busy <= kind_start;
                stop_irq <= !kind_start && !master_q;
            end
        end
    end

    // assertions
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq);

    a_r9_irq_slave_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> (!bus_busy && !master_q));

    a_r10_err_disables: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> (state == ST_OFF));

    a_r2_busy_from_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_busy) |-> ($past(state) == ST_HOLD || $past(state) == ST_WAIT));

    a_r8_wait_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> ($past(state) == ST_HOLD || $past(state) == ST_WAIT));
endmodule

// File: tb/test_i2c_cond_detect.sv
module test_i2c_cond_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_ssc = 5'd24;
    logic       cfg_fast = 1'b0, cfg_master = 1'b0;
    logic       bus_busy, stop_irq, cfg_err;

    int nchk = 0;
    int nerr = 0;
    logic bb_model = 1'b0;

    always #2 clk = ~clk;

    i2c_cond_detect i_i2c_cond_detect (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .cfg_we(cfg_we), .cfg_ssc(cfg_ssc), .cfg_fast(cfg_fast), .cfg_master(cfg_master),
        .bus_busy(bus_busy), .stop_irq(stop_irq), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic       fast;
        logic [4:0] ssc;
        logic       is_start;
        logic [7:0] rel;
        logic [7:0] setup;
        logic [7:0] hold;
        logic       det;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd24, 1'b1, 8'd25, 8'd13, 8'd12, 1'b1},
        '{1'b0, 5'd24, 1'b0, 8'd25, 8'd13, 8'd12, 1'b1},
        '{1'b0, 5'd24, 1'b1, 8'd24, 8'd13, 8'd12, 1'b0},
        '{1'b0, 5'd24, 1'b1, 8'd25, 8'd12, 8'd12, 1'b0},
        '{1'b0, 5'd24, 1'b1, 8'd25, 8'd13, 8'd11, 1'b0},
        '{1'b0, 5'd24, 1'b1, 8'd40, 8'd20, 8'd20, 1'b1},
        '{1'b0, 5'd24, 1'b0, 8'd25, 8'd13, 8'd11, 1'b0},
        '{1'b0, 5'd24, 1'b0, 8'd30, 8'd30, 8'd12, 1'b1},
        '{1'b0, 5'd8,  1'b1, 8'd9,  8'd5,  8'd4,  1'b1},
        '{1'b0, 5'd8,  1'b0, 8'd8,  8'd5,  8'd4,  1'b0},
        '{1'b0, 5'd8,  1'b0, 8'd9,  8'd5,  8'd4,  1'b1},
        '{1'b1, 5'd30, 1'b1, 8'd4,  8'd2,  8'd2,  1'b1},
        '{1'b1, 5'd30, 1'b0, 8'd3,  8'd2,  8'd2,  1'b0},
        '{1'b1, 5'd30, 1'b0, 8'd4,  8'd2,  8'd2,  1'b1},
        '{1'b1, 5'd30, 1'b1, 8'd4,  8'd1,  8'd2,  1'b0},
        '{1'b1, 5'd30, 1'b1, 8'd4,  8'd2,  8'd1,  1'b0},
        '{1'b0, 5'd2,  1'b1, 8'd3,  8'd2,  8'd1,  1'b1},
        '{1'b0, 5'd2,  1'b0, 8'd3,  8'd2,  8'd1,  1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [4:0] ssc, input logic fast, input logic master);
        @(negedge clk);
        cfg_ssc = ssc; cfg_fast = fast; cfg_master = master; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Flag delay from R4/R5
    function automatic int delay_of(input logic fast, input logic [4:0] ssc);
        return fast ? 4 : (int'(ssc) / 2 + 1);
    endfunction

    // Drive one candidate condition and check both outputs on every cycle
    task automatic cond(input logic is_start, input int rel, input int setup, input int hold,
                        input int dly, input logic det, input logic master, input string tag);
        logic old_lvl;
        logic exp_bb, exp_irq;
        int   last;
        old_lvl = is_start;
        @(negedge clk);
        scl_in = 1'b0; sda_in = !old_lvl;
        repeat (2) @(negedge clk);
        if (setup >= rel) begin
            sda_in = old_lvl;
            repeat (setup - rel) @(negedge clk);
            scl_in = 1'b1;
            repeat (rel) @(negedge clk);
        end else begin
            scl_in = 1'b1;
            repeat (rel - setup) @(negedge clk);
            sda_in = old_lvl;
            repeat (setup) @(negedge clk);
        end
        sda_in = !old_lvl;   // first sampled at edge e0
        last = (hold > dly + 2) ? hold : dly + 2;
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);  // edge e0+i has passed
            if (i == hold - 1) scl_in = 1'b0;
            exp_bb  = (det && i >= dly + 1) ? is_start : bb_model;
            exp_irq = det && !is_start && !master && (i == dly + 1);
            chk(tag, bus_busy, exp_bb);
            chk({tag, " R9 irq"}, stop_irq, exp_irq);
        end
        if (det) bb_model = is_start;
    endtask

    function automatic string tag_of(input vec_t v);
        int r, s, h;
        r = v.fast ? 4 : int'(v.ssc) + 1;
        s = v.fast ? 2 : int'(v.ssc) / 2 + 1;
        h = v.fast ? 2 : int'(v.ssc) / 2;
        if (!v.det) begin
            if (int'(v.rel) < r)        return "R6 release short";
            else if (int'(v.setup) < s) return "R7 setup short";
            else if (int'(v.hold) < h)  return "R8 hold short";
            return "R8";
        end
        if (v.fast)                return "R5 fast";
        if (v.ssc != 5'd24)        return "R4 window";
        return v.is_start ? "R2 start" : "R3 stop";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog R1..: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus_busy reset", bus_busy, 1'b0);
        chk("R1 stop_irq reset", stop_irq, 1'b0);
        chk("R1 cfg_err reset", cfg_err, 1'b0);

        // R1: reset defaults act as timing value 24, standard, slave
        cond(1'b1, 25, 13, 12, 13, 1'b1, 1'b0, "R1 default start");
        cond(1'b0, 25, 13, 12, 13, 1'b1, 1'b0, "R1 default stop");

        // table walk
        for (int k = 0; k < NV; k++) begin
            cfg_write(VECS[k].ssc, VECS[k].fast, 1'b0);
            cond(VECS[k].is_start, int'(VECS[k].rel), int'(VECS[k].setup), int'(VECS[k].hold),
                 delay_of(VECS[k].fast, VECS[k].ssc), VECS[k].det, 1'b0, tag_of(VECS[k]));
        end

        // R9: master role gives no stop pulse
        cfg_write(5'd24, 1'b0, 1'b1);
        cond(1'b1, 25, 13, 12, 13, 1'b1, 1'b1, "R9 master start");
        cond(1'b0, 25, 13, 12, 13, 1'b1, 1'b1, "R9 master stop");

        // R10: illegal values
        cfg_write(5'd7, 1'b0, 1'b0);
        chk("R10 odd sets cfg_err", cfg_err, 1'b1);
        cond(1'b1, 25, 13, 12, 13, 1'b0, 1'b0, "R10 disabled");
        cfg_write(5'd0, 1'b0, 1'b0);
        chk("R10 zero keeps cfg_err", cfg_err, 1'b1);
        cfg_write(5'd24, 1'b0, 1'b0);
        chk("R10 legal clears cfg_err", cfg_err, 1'b0);
        cond(1'b1, 25, 13, 12, 13, 1'b1, 1'b0, "R10 re-enabled start");
        cond(1'b0, 25, 13, 12, 13, 1'b1, 1'b0, "R10 re-enabled stop");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule